// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block walks a processor core through taking a trap and coming back from one. It accepts four fixed-cause exception requests, a software interrupt carrying an 8-bit number, a break request, a return-from-trap request and a sleep request. It owns the program counter, the stack pointer and the status word. Entry fetches a handler address over a single-outstanding memory port, saves the old status word and the return address on the stack, drops the interrupt-enable, user-stack and user-mode bits, and then jumps to the handler. Return pops the return address and then the status word.

Fixed causes take their handler address from fixed words near the top of the address space. Software interrupts and break take it from a table whose base is given on an input. A fixed-cause handler word equal to zero or to a marker value counts as not installed. A break with a zero table base does the same. In both cases the block stops in a sticky fatal state and takes no further action until reset. Fixed-cause requests that arrive together are held pending and served one after another in a fixed priority order.

Top module: `trap_seq`

## Requirements
- R1: After reset pc_o = RESET_PC (0x100), sp_o = RESET_SP (0x1000), psw_o = 0, and busy, halted and sleep_o are 0.
- R2: exc_req bit 0 is access violation, bit 1 is undefined opcode, bit 2 is privileged and bit 3 is floating point. Their handler words are read from 0xFFFFFFD4, 0xFFFFFFDC, 0xFFFFFFD0 and 0xFFFFFFE4.
- R3: Entry writes the old status word to SP-4 and then the return address to SP-8. It leaves sp_o at SP-8 and loads pc_o with the handler word. A fixed cause uses inst_pc as the return address.
- R4: On entry psw_o bits 16 (interrupt enable), 17 (user stack) and 20 (user mode) are cleared and every other bit is kept. These bits are already clear while the stack writes are in flight.
- R5: A fixed-cause handler word of 0 or 0x00020000 sets halted. No stack write follows, and pc_o, sp_o and psw_o keep their values. The halt is sticky, and every later request has no effect.
- R6: A software interrupt with number n reads its handler from intb + 4*n and pushes next_pc as the return address.
- R7: A break reads its handler from intb itself and pushes next_pc. With intb = 0 it sets halted and makes no memory access.
- R8: Return reads the new pc from SP and the new status word from SP+4, and leaves sp_o at SP+8. If bit 20 of the popped status word is 1, bit 17 is forced to 1. Otherwise the word is taken as read.
- R9: A return or sleep request while psw_o bit 20 is 1 raises the privileged exception, with inst_pc as the return address.
- R10: Fixed causes requested in the same cycle are all served, in the order access, undefined, privileged, floating point. Each one is a complete entry.
- R11: busy is 1 from the edge that accepts a request until the edge that updates pc_o. ret_req, sleep_req, brk_req and swi_req strobes while busy is 1 have no effect.
- R12: The memory port has one access at a time. mem_req, mem_we, mem_addr and mem_wdata stay stable until the cycle with mem_ready. A transfer happens on an edge where mem_req and mem_ready are both 1.
- R13: A sleep request while bit 20 is 0 sets psw_o bit 16 and gives a one-cycle pulse on sleep_o. It makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 4 | Fixed-cause exception request strobes |
| ret_req | input | 1 | Return-from-trap request strobe |
| sleep_req | input | 1 | Sleep (privileged) request strobe |
| swi_req | input | 1 | Software interrupt request strobe |
| swi_num | input | 8 | Software interrupt number |
| brk_req | input | 1 | Break request strobe |
| inst_pc | input | 32 | Address of the instruction that faulted |
| next_pc | input | 32 | Address following the requesting instruction |
| intb | input | 32 | Base of the interrupt handler table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or completes the access |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| pc_o | output | 32 | Program counter |
| sp_o | output | 32 | Stack pointer |
| psw_o | output | 32 | Status word |
| busy | output | 1 | A trap sequence is in progress or pending |
| halted | output | 1 | Sticky fatal stop for a missing handler |
| sleep_o | output | 1 | One-cycle pulse for a granted sleep |

## Verification
The bench raises all four fixed causes in one cycle and follows the stack writes one by one. A wrong priority order, or a cause that is dropped after another one wins, shows up as a write at the wrong address or with the wrong data. It returns once with bit 20 set and once with it clear. A design that forces bit 17 on every pop, or never forces it, leaves the wrong status word. A return attempted in user mode has to become a privileged trap, not a pop. Each of the three fatal paths runs from a fresh reset: a zero word, the marker word, and a break with a zero base. A design that still pushes, moves the stack pointer or answers a later software interrupt shows up as unexpected writes or changed registers. A break strobed while busy, and read stalls of zero to two cycles, catch a design that takes side requests mid-sequence or changes the address of an access before it completes.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN     = 32;
    localparam int NUM_EXC  = 4;
    localparam int EXC_IW   = $clog2(NUM_EXC);

    // exception request bit positions, bit 0 has the highest priority
    localparam int EXC_ACCESS = 0;
    localparam int EXC_UNDEF  = 1;
    localparam int EXC_PRIV   = 2;
    localparam int EXC_FPU    = 3;

    // status word bit positions
    localparam int PSW_IE_BIT   = 16;
    localparam int PSW_USTK_BIT = 17;
    localparam int PSW_UMOD_BIT = 20;

    localparam logic [XLEN-1:0] FIXED_VEC_BASE = 32'hFFFF_FFD0;
    localparam logic [XLEN-1:0] WORD_BYTES     = 32'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_PUSH_PSW,
        ST_PUSH_PC,
        ST_POP_PC,
        ST_POP_PSW,
        ST_HALT
    } trap_state_e;

    typedef enum logic [1:0] {
        VK_FIXED,
        VK_SWI,
        VK_BRK
    } vec_kind_e;

    typedef struct packed {
        trap_state_e     state;
        vec_kind_e       kind;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] psw;
        logic [XLEN-1:0] old_psw;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] vec;
        logic [XLEN-1:0] vaddr;
        logic            sleep;
    } trap_regs_t;
endpackage

// File: rtl/trap_vec_addr.sv
module trap_vec_addr
    import trap_pkg::*;
#(
    parameter int SWI_W = 8,
    parameter int IDX_W = EXC_IW
) (
    input  vec_kind_e             kind,
    input  logic [IDX_W-1:0]      exc_idx,
    input  logic [SWI_W-1:0]      swi_num,
    input  logic [XLEN-1:0]       intb,
    output logic [XLEN-1:0]       addr
);
    localparam int PAD_W = XLEN - SWI_W - 2;

    logic [XLEN-1:0] fixed_off;
    logic [XLEN-1:0] swi_off;

    // offset of each fixed cause word from the fixed base
    always_comb begin
        case (int'(exc_idx))
            EXC_ACCESS: fixed_off = 32'h04;
            EXC_UNDEF:  fixed_off = 32'h0C;
            EXC_PRIV:   fixed_off = 32'h00;
            default:    fixed_off = 32'h14;
        endcase
    end

    assign swi_off = {{PAD_W{1'b0}}, swi_num, 2'b00};

    always_comb begin
        case (kind)
            VK_FIXED: addr = FIXED_VEC_BASE + fixed_off;
            VK_SWI:   addr = intb + swi_off;
            default:  addr = intb;
        endcase
    end
endmodule

// File: rtl/trap_pend_arb.sv
module trap_pend_arb #(
    parameter int N  = 4,
    parameter int W  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_i,
    input  logic [W-1:0]  set_pc,
    input  logic          clr_i,
    output logic          pend_any,
    output logic [IW-1:0] grant_idx,
    output logic [W-1:0]  grant_pc
);
    logic [N-1:0] pend_d, pend_q;
    logic [W-1:0] pc_d [N];
    logic [W-1:0] pc_q [N];

    // lowest pending index wins
    always_comb begin
        grant_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) grant_idx = IW'(i);
        end
    end

    assign pend_any = |pend_q;
    assign grant_pc = pc_q[grant_idx];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_comb begin
            pend_d[g] = set_i[g] | (pend_q[g] & ~(clr_i && (grant_idx == IW'(g))));
            pc_d[g]   = set_i[g] ? set_pc : pc_q[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
                pc_q[g]   <= '0;
            end else begin
                pend_q[g] <= pend_d[g];
                pc_q[g]   <= pc_d[g];
            end
        end
    end

    // R10: a served cause is gone next cycle unless raised again
    a_r10_served_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i[grant_idx]) |=> !pend_q[$past(grant_idx)]);

    // R10: the sequencer only takes a cause that is pending
    a_r10_clear_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> pend_q[grant_idx]);
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter logic [31:0] RESET_PC  = 32'h0000_0100,
    parameter logic [31:0] RESET_SP  = 32'h0000_1000,
    parameter logic [31:0] RESET_PSW = 32'h0000_0000,
    parameter logic [31:0] UNSET_VEC = 32'h0002_0000,
    parameter int          SWI_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       exc_req,
    input  logic             ret_req,
    input  logic             sleep_req,
    input  logic             swi_req,
    input  logic [SWI_W-1:0] swi_num,
    input  logic             brk_req,
    input  logic [31:0]      inst_pc,
    input  logic [31:0]      next_pc,
    input  logic [31:0]      intb,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata,
    output logic [31:0]      pc_o,
    output logic [31:0]      sp_o,
    output logic [31:0]      psw_o,
    output logic             busy,
    output logic             halted,
    output logic             sleep_o
);
    localparam logic [XLEN-1:0] MODE_MASK =
        (XLEN'(1) << PSW_IE_BIT) | (XLEN'(1) << PSW_USTK_BIT) | (XLEN'(1) << PSW_UMOD_BIT);

    trap_regs_t r_d, r_q;

    logic [NUM_EXC-1:0] pset;
    logic               pclr;
    logic               pend_any;
    logic [EXC_IW-1:0]  grant_idx;
    logic [XLEN-1:0]    grant_pc;
    vec_kind_e          sel_kind;
    logic [XLEN-1:0]    sel_vaddr;
    logic               umode;

    assign umode = r_q.psw[PSW_UMOD_BIT];

    trap_pend_arb #(
        .N  (NUM_EXC),
        .W  (XLEN),
        .IW (EXC_IW)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (pset),
        .set_pc    (inst_pc),
        .clr_i     (pclr),
        .pend_any  (pend_any),
        .grant_idx (grant_idx),
        .grant_pc  (grant_pc)
    );

    // kind of the request that would be accepted this cycle
    always_comb begin
        if (pend_any)     sel_kind = VK_FIXED;
        else if (brk_req) sel_kind = VK_BRK;
        else              sel_kind = VK_SWI;
    end

    trap_vec_addr #(
        .SWI_W (SWI_W),
        .IDX_W (EXC_IW)
    ) u_vec (
        .kind    (sel_kind),
        .exc_idx (grant_idx),
        .swi_num (swi_num),
        .intb    (intb),
        .addr    (sel_vaddr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.sleep = 1'b0;
        pclr      = 1'b0;
        pset      = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        // fixed causes are captured in every state but the fatal one
        if (r_q.state != ST_HALT) pset = exc_req;

        case (r_q.state)
            ST_IDLE: begin
                if (pend_any) begin
                    pclr      = 1'b1;
                    r_d.kind  = VK_FIXED;
                    r_d.vaddr = sel_vaddr;
                    r_d.epc   = grant_pc;
                    r_d.state = ST_VEC;
                end else if (ret_req) begin
                    if (umode) pset[EXC_PRIV] = 1'b1;
                    else       r_d.state = ST_POP_PC;
                end else if (sleep_req) begin
                    if (umode) begin
                        pset[EXC_PRIV] = 1'b1;
                    end else begin
                        r_d.psw[PSW_IE_BIT] = 1'b1;
                        r_d.sleep           = 1'b1;
                    end
                end else if (brk_req) begin
                    if (intb == '0) begin
                        r_d.state = ST_HALT;
                    end else begin
                        r_d.kind  = VK_BRK;
                        r_d.vaddr = sel_vaddr;
                        r_d.epc   = next_pc;
                        r_d.state = ST_VEC;
                    end
                end else if (swi_req) begin
                    r_d.kind  = VK_SWI;
                    r_d.vaddr = sel_vaddr;
                    r_d.epc   = next_pc;
                    r_d.state = ST_VEC;
                end
            end

            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.vaddr;
                if (mem_ready) begin
                    if (r_q.kind == VK_FIXED &&
                        (mem_rdata == '0 || mem_rdata == UNSET_VEC)) begin
                        r_d.state = ST_HALT;
                    end else begin
                        r_d.vec     = mem_rdata;
                        r_d.old_psw = r_q.psw;
                        r_d.psw     = r_q.psw & ~MODE_MASK;
                        r_d.state   = ST_PUSH_PSW;
                    end
                end
            end

            ST_PUSH_PSW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - WORD_BYTES;
                mem_wdata = r_q.old_psw;
                if (mem_ready) begin
                    r_d.sp    = r_q.sp - WORD_BYTES;
                    r_d.state = ST_PUSH_PC;
                end
            end

            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - WORD_BYTES;
                mem_wdata = r_q.epc;
                if (mem_ready) begin
                    r_d.sp    = r_q.sp - WORD_BYTES;
                    r_d.pc    = r_q.vec;
                    r_d.state = ST_IDLE;
                end
            end

            ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                if (mem_ready) begin
                    r_d.vec   = mem_rdata;
                    r_d.sp    = r_q.sp + WORD_BYTES;
                    r_d.state = ST_POP_PSW;
                end
            end

            ST_POP_PSW: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                if (mem_ready) begin
                    r_d.psw = mem_rdata;
                    if (mem_rdata[PSW_UMOD_BIT]) r_d.psw[PSW_USTK_BIT] = 1'b1;
                    r_d.sp    = r_q.sp + WORD_BYTES;
                    r_d.pc    = r_q.vec;
                    r_d.state = ST_IDLE;
                end
            end

            default: begin
                // fatal stop: hold everything until reset
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.kind    <= VK_FIXED;
            r_q.pc      <= RESET_PC;
            r_q.sp      <= RESET_SP;
            r_q.psw     <= RESET_PSW;
            r_q.old_psw <= '0;
            r_q.epc     <= '0;
            r_q.vec     <= '0;
            r_q.vaddr   <= '0;
            r_q.sleep   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o    = r_q.pc;
    assign sp_o    = r_q.sp;
    assign psw_o   = r_q.psw;
    assign sleep_o = r_q.sleep;
    assign halted  = (r_q.state == ST_HALT);
    assign busy    = !halted && ((r_q.state != ST_IDLE) || pend_any);

    // R12: an access waiting for ready keeps its request, kind, address and data
    a_r12_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R11: no memory traffic outside a busy sequence
    a_r11_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R3: the stack pointer moves one word at a time
    a_r3_sp_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_o) |-> ((sp_o == $past(sp_o) - 32'd4) || (sp_o == $past(sp_o) + 32'd4)));

    // R4: the mode bits are already clear while the stack is written
    a_r4_mode_clear_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((psw_o & MODE_MASK) == '0));

    // R5: the fatal stop is sticky and freezes the architectural state
    a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_o) && $stable(sp_o) && $stable(psw_o)));

    // R13: a sleep pulse lasts one cycle
    a_r13_sleep_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> !sleep_o);
endmodule

// File: tb/sim_trap_seq.sv
`timescale 1ns/1ps
module sim_trap_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  exc_req = '0;
    logic        ret_req = 1'b0, sleep_req = 1'b0, swi_req = 1'b0, brk_req = 1'b0;
    logic [7:0]  swi_num = '0;
    logic [31:0] inst_pc = '0, next_pc = '0, intb = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] pc_o, sp_o, psw_o;
    logic        busy, halted, sleep_o;

    always #4 clk = ~clk;

    trap_seq u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_req(ret_req),
        .sleep_req(sleep_req), .swi_req(swi_req), .swi_num(swi_num),
        .brk_req(brk_req), .inst_pc(inst_pc), .next_pc(next_pc), .intb(intb),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .sp_o(sp_o), .psw_o(psw_o), .busy(busy),
        .halted(halted), .sleep_o(sleep_o)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q[$];

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem [logic [31:0]];
    logic        poke_en = 1'b0;
    logic [31:0] poke_a = '0, poke_d = '0;
    int          lat = 0;
    int          lat_pat = 0;
    logic        stalled = 1'b0;
    logic [31:0] stall_addr = '0;

    // memory model and write scoreboard monitor
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            if (poke_en) mem[poke_a] = poke_d;
            if (stalled) begin
                n_tests++;
                if (mem_addr !== stall_addr) begin
                    n_fail++;
                    $display("FAIL R12 address moved while stalled: got %h expected %h",
                             mem_addr, stall_addr);
                end
            end
            stalled = mem_req && !mem_ready;
            stall_addr = mem_addr;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    n_tests++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R3 unexpected write: got %h<=%h expected none",
                                 mem_addr, mem_wdata);
                    end else begin
                        wr_t e;
                        e = exp_q.pop_front();
                        if (e.a !== mem_addr || e.d !== mem_wdata) begin
                            n_fail++;
                            $display("FAIL R3 stack write: got %h<=%h expected %h<=%h",
                                     mem_addr, mem_wdata, e.a, e.d);
                        end
                    end
                end
                lat_pat = (lat_pat + 1) % 3;
                lat = lat_pat;
            end else if (mem_req && lat > 0) begin
                lat = lat - 1;
            end
            @(negedge clk);
            mem_ready = mem_req && (lat == 0);
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic expect_entry(input logic [31:0] sp, input logic [31:0] psw,
                                input logic [31:0] ret);
        exp_q.push_back('{a: sp - 32'd4, d: psw});
        exp_q.push_back('{a: sp - 32'd8, d: ret});
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_exc(input logic [3:0] bits, input logic [31:0] ipc);
        @(negedge clk);
        exc_req = bits; inst_pc = ipc;
        @(negedge clk);
        exc_req = '0;
        wait_idle();
    endtask

    task automatic pulse_ret(input logic [31:0] ipc);
        @(negedge clk);
        ret_req = 1'b1; inst_pc = ipc;
        @(negedge clk);
        ret_req = 1'b0;
        wait_idle();
    endtask

    task automatic pulse_swi(input logic [7:0] n, input logic [31:0] npc);
        @(negedge clk);
        swi_req = 1'b1; swi_num = n; next_pc = npc;
        @(negedge clk);
        swi_req = 1'b0;
        wait_idle();
    endtask

    task automatic pulse_brk(input logic [31:0] npc);
        @(negedge clk);
        brk_req = 1'b1; next_pc = npc;
        @(negedge clk);
        brk_req = 1'b0;
        wait_idle();
    endtask

    task automatic restore(input logic [31:0] ret, input logic [31:0] psw,
                           input logic [31:0] exp_psw);
        logic [31:0] sp0;
        sp0 = sp_o;
        poke(sp0, ret);
        poke(sp0 + 32'd4, psw);
        pulse_ret(32'hDEAD_0000);
        chk("R8 pc after return", pc_o, ret);
        chk("R8 sp after return", sp_o, sp0 + 32'd8);
        chk("R8 psw after return", psw_o, exp_psw);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        poke_en = 1'b0;
        do_reset();

        // R1 reset state
        chk("R1 pc", pc_o, 32'h100);
        chk("R1 sp", sp_o, 32'h1000);
        chk("R1 psw", psw_o, 32'h0);
        chk("R1 busy/halted/sleep", {29'd0, busy, halted, sleep_o}, 32'h0);

        // handler words
        poke(32'hFFFF_FFD0, 32'h3100);
        poke(32'hFFFF_FFD4, 32'h3000);
        poke(32'hFFFF_FFDC, 32'h3200);
        poke(32'hFFFF_FFE4, 32'h3300);
        poke(32'h8014, 32'h4000);
        poke(32'h8000, 32'h4100);

        // R8: user mode popped -> user stack bit forced
        restore(32'h2000, 32'h0011_0005, 32'h0013_0005);

        // R2 R3 R4: access violation entry
        expect_entry(32'h1008, 32'h0013_0005, 32'h2004);
        pulse_exc(4'b0001, 32'h2004);
        chk("R2 R3 pc from access word", pc_o, 32'h3000);
        chk("R3 sp", sp_o, 32'h1000);
        chk("R4 psw mode bits cleared, others kept", psw_o, 32'h0000_0005);
        chk("R3 all writes seen", exp_q.size(), 0);

        // R9: return while in user mode becomes a privileged trap
        restore(32'h2100, 32'h0011_0000, 32'h0013_0000);
        expect_entry(32'h1008, 32'h0013_0000, 32'h2104);
        pulse_ret(32'h2104);
        chk("R9 pc from privileged word", pc_o, 32'h3100);
        chk("R9 sp", sp_o, 32'h1000);
        chk("R9 psw", psw_o, 32'h0);
        chk("R9 writes seen", exp_q.size(), 0);

        // R10: all four at once, served in priority order
        expect_entry(32'h1000, 32'h0, 32'h2200);
        expect_entry(32'h0FF8, 32'h0, 32'h2200);
        expect_entry(32'h0FF0, 32'h0, 32'h2200);
        expect_entry(32'h0FE8, 32'h0, 32'h2200);
        pulse_exc(4'b1111, 32'h2200);
        chk("R10 pc from floating point word last", pc_o, 32'h3300);
        chk("R10 sp after four entries", sp_o, 32'h0FE0);
        chk("R10 writes seen", exp_q.size(), 0);

        // R6 R11: software interrupt, with a break strobed while busy
        intb = 32'h8000;
        expect_entry(32'h0FE0, 32'h0, 32'h2300);
        @(negedge clk);
        swi_req = 1'b1; swi_num = 8'd5; next_pc = 32'h2300;
        @(negedge clk);
        swi_req = 1'b0;
        chk("R11 busy after acceptance", {31'd0, busy}, 32'h1);
        brk_req = 1'b1; next_pc = 32'h9999;
        @(negedge clk);
        brk_req = 1'b0;
        wait_idle();
        chk("R6 pc from intb+4n", pc_o, 32'h4000);
        chk("R6 sp", sp_o, 32'h0FD8);
        chk("R11 ignored break left no writes", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        chk("R11 ignored break did not move pc", pc_o, 32'h4000);

        // R7: break
        expect_entry(32'h0FD8, 32'h0, 32'h2400);
        pulse_brk(32'h2400);
        chk("R7 pc from intb word", pc_o, 32'h4100);
        chk("R7 sp", sp_o, 32'h0FD0);

        // R13: sleep in supervisor mode
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R13 sleep pulse", {31'd0, sleep_o}, 32'h1);
        chk("R13 interrupt enable set", psw_o, 32'h0001_0000);
        @(negedge clk);
        chk("R13 pulse is one cycle", {31'd0, sleep_o}, 32'h0);

        // R8: return with user mode clear, no forcing
        pulse_ret(32'h0);
        chk("R8 pc popped", pc_o, 32'h2400);
        chk("R8 sp popped", sp_o, 32'h0FD8);
        chk("R8 psw popped as read", psw_o, 32'h0);

        // R5: zero word for floating point
        do_reset();
        poke(32'hFFFF_FFE4, 32'h0);
        pulse_exc(4'b1000, 32'h5000);
        chk("R5 halted on zero word", {31'd0, halted}, 32'h1);
        chk("R5 sp kept", sp_o, 32'h1000);
        chk("R5 pc kept", pc_o, 32'h100);
        pulse_swi(8'd5, 32'h5004);
        chk("R5 later request has no effect on pc", pc_o, 32'h100);
        chk("R5 still halted", {31'd0, halted}, 32'h1);

        // R7: break with zero base
        do_reset();
        intb = 32'h0;
        pulse_brk(32'h6000);
        chk("R7 halted with zero base", {31'd0, halted}, 32'h1);
        chk("R7 sp kept", sp_o, 32'h1000);

        // R5: marker word for undefined opcode
        do_reset();
        poke(32'hFFFF_FFDC, 32'h0002_0000);
        pulse_exc(4'b0010, 32'h7000);
        chk("R5 halted on marker word", {31'd0, halted}, 32'h1);
        chk("R5 psw kept", psw_o, 32'h0);
        chk("R5 pc kept on marker", pc_o, 32'h100);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule